// File: doc/BRIEF.md
# Extended-State Enable Register Controller

This block holds a 64-bit control register in which each bit from 0 to 62 switches one group of processor state on for save and restore. Bit 0 is the base floating-point group and is always on. Bit 1 is the vector-register and control/status group. Bit 63 never stands for a state group. Software writes the register through a simple port: a valid strobe, 64 bits of data and the current privilege level.

Each write is checked against a fixed capability mask, which is a parameter, and against the privilege rule. A legal write takes effect at the next clock edge and is visible on the read-back output. A write is illegal if it comes from a nonzero privilege level, clears bit 0, or sets a bit outside the supported mask. An illegal write leaves the register unchanged and produces a single one-cycle fault pulse with a cause code.

A combinational side output gives the effective save set. This is the register ANDed with a save mask that the requester supplies, so only enabled groups can ever be saved.

Top module: `xstate_enable_ctrl`

## Requirements
- R1: After reset the register reads 64'h1, `fault` is 0 and `fault_cause` is 2'b00.
- R2: A write with privilege 0, bit 0 set and no bit outside the effective capability mask loads the written value at the next clock edge, and the read-back output shows it from that edge on.
- R3: A write with bit 0 clear is rejected, the register keeps its value, and bit 0 of the register always reads 1.
- R4: A write that sets any bit outside the effective capability mask is rejected and leaves the register unchanged; with the default mask (64'h3), bits 2 to 63 are outside the mask.
- R5: A write whose privilege input is not 0 is rejected and leaves the register unchanged, even when the data would be legal.
- R6: `fault` is high for exactly the one cycle after each rejected write strobe. It stays low after accepted writes and after cycles with no strobe, and data presented without a strobe has no effect on the register.
- R7: `fault_cause` reports one cause per rejected write: 2'b01 for privilege, 2'b10 for bit 0 clear, 2'b11 for an unsupported bit. When several causes apply it reports the first in that order. It reads 2'b00 whenever `fault` is low.
- R8: `save_set` equals the register ANDed with `save_req`, with no clock delay.
- R9: The effective capability mask is the `SUPPORTED` parameter with bit 0 forced to 1 and bit 63 forced to 0. A write of bit 63 is therefore always rejected, and bit 0 is always writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 64 | Value to write |
| wr_priv | input | 2 | Privilege level of the writer, 0 is the most privileged |
| save_req | input | 64 | Requested save mask |
| enable_q | output | 64 | Read-back of the enable register |
| save_set | output | 64 | Effective save set, `enable_q & save_req` |
| fault | output | 1 | One-cycle pulse after a rejected write |
| fault_cause | output | 2 | Cause of the pulse (01 privilege, 10 bit 0 clear, 11 unsupported bit, 00 none) |

## Verification
The hardest case to reach is a write that breaks more than one rule at once, because the cause priority only shows when the causes overlap. The stimulus builds writes that combine a nonzero privilege, a clear bit 0 and unsupported bits, including bit 63. It also sends rejected strobes back to back, so that the pulse has to stay one per strobe rather than stretch or merge. A second instance has a capability parameter with bit 0 clear and bit 63 set, which shows that the forcing of those two bits overrides the parameter.

// File: rtl/xsec_pkg.sv
package xsec_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PRIV = 2'b01,
    CAUSE_BASE = 2'b10,
    CAUSE_RSVD = 2'b11
  } cause_e;
endpackage

// File: rtl/xsec_legality.sv
module xsec_legality
  import xsec_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PRIV_W = 2,
  parameter logic [DATA_W-1:0] CAP = '1
) (
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PRIV_W-1:0] wr_priv,
  output logic              legal,
  output cause_e            cause
);
  logic [DATA_W-1:0] unsup_hit;

  // per-bit detection of bits the capability mask does not allow
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (CAP[i]) begin : g_ok
      assign unsup_hit[i] = 1'b0;
    end else begin : g_bad
      assign unsup_hit[i] = wr_data[i];
    end
  end

  always_comb begin
    if (wr_priv != '0)       cause = CAUSE_PRIV;
    else if (!wr_data[0])    cause = CAUSE_BASE;
    else if (|unsup_hit)     cause = CAUSE_RSVD;
    else                     cause = CAUSE_NONE;
    legal = (cause == CAUSE_NONE);
  end
endmodule

// File: rtl/xsec_state_reg.sv
module xsec_state_reg #(
  parameter int unsigned DATA_W = 64,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] state_q
);
  logic [DATA_W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (load_en) state_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RESET_VAL;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/xsec_fault.sv
module xsec_fault
  import xsec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   strobe,
  input  logic   legal,
  input  cause_e cause,
  output logic   fault_q,
  output cause_e cause_q
);
  logic   fault_d;
  cause_e cause_d;

  always_comb begin
    fault_d = strobe && !legal;
    cause_d = fault_d ? cause : CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/xstate_enable_ctrl.sv
module xstate_enable_ctrl
  import xsec_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PRIV_W = 2,
  parameter logic [DATA_W-1:0] SUPPORTED = 64'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PRIV_W-1:0] wr_priv,
  input  logic [DATA_W-1:0] save_req,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] save_set,
  output logic              fault,
  output logic [1:0]        fault_cause
);
  localparam logic [DATA_W-1:0] BASE_BIT  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] LOW_BITS  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] CAP_EFF   = (SUPPORTED | BASE_BIT) & LOW_BITS;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic   legal;
  cause_e cause, cause_q;

  xsec_legality #(.DATA_W(DATA_W), .PRIV_W(PRIV_W), .CAP(CAP_EFF)) u_chk (
    .wr_data (wr_data),
    .wr_priv (wr_priv),
    .legal   (legal),
    .cause   (cause)
  );

  xsec_state_reg #(.DATA_W(DATA_W), .RESET_VAL(BASE_BIT)) u_reg (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_en  (wr_valid && legal),
    .load_val (wr_data),
    .state_q  (enable_q)
  );

  xsec_fault u_fault (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .strobe  (wr_valid),
    .legal   (legal),
    .cause   (cause),
    .fault_q (fault),
    .cause_q (cause_q)
  );

  assign fault_cause = cause_q;
  assign save_set    = enable_q & save_req;
endmodule

// File: rtl/xsec_checker.sv
module xsec_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PRIV_W = 2,
  parameter logic [DATA_W-1:0] CAP = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic [PRIV_W-1:0] wr_priv,
  input logic [DATA_W-1:0] save_req,
  input logic [DATA_W-1:0] enable_q,
  input logic [DATA_W-1:0] save_set,
  input logic              fault,
  input logic [1:0]        fault_cause
);
  logic bad_wr;
  assign bad_wr = wr_valid &&
                  ((wr_priv != '0) || !wr_data[0] || ((wr_data & ~CAP) != '0));

  assert_base_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enable_q[0]);

  assert_no_unsup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q & ~CAP) == '0);

  assert_top_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q[DATA_W-1]);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !bad_wr) |=> (enable_q == $past(wr_data)) && !fault);

  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> fault && $stable(enable_q));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !fault && $stable(enable_q));

  assert_priv_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_priv != '0) |=> $stable(enable_q) && fault_cause == 2'b01);

  assert_idle_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> fault_cause == 2'b00);

  assert_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((save_set & ~enable_q) == '0) && ((save_set & ~save_req) == '0));
endmodule

bind xstate_enable_ctrl xsec_checker #(.DATA_W(DATA_W), .PRIV_W(PRIV_W), .CAP(CAP_EFF)) u_xsec_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .wr_valid    (wr_valid),
  .wr_data     (wr_data),
  .wr_priv     (wr_priv),
  .save_req    (save_req),
  .enable_q    (enable_q),
  .save_set    (save_set),
  .fault       (fault),
  .fault_cause (fault_cause)
);

// File: tb/xstate_enable_ctrl_test.sv
`timescale 1ns/1ps
module xstate_enable_ctrl_test;
  typedef struct {
    logic [63:0] en;
    logic        flt;
    logic [1:0]  cause;
    string       tag;
  } exp_t;

  localparam logic [63:0] CAP_DEF = 64'h3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [63:0] wr_data;
  logic [1:0]  wr_priv;
  logic [63:0] save_req;
  logic [63:0] enable_q, save_set;
  logic        fault;
  logic [1:0]  fault_cause;

  logic        w_valid;
  logic [63:0] w_data;
  logic [63:0] w_enable, w_save;
  logic        w_fault;
  logic [1:0]  w_cause;

  exp_t        q[$];
  logic [63:0] model_en;
  int          tests = 0;
  int          fails = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  xstate_enable_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_priv(wr_priv), .save_req(save_req), .enable_q(enable_q),
    .save_set(save_set), .fault(fault), .fault_cause(fault_cause)
  );

  xstate_enable_ctrl #(.SUPPORTED(64'h8000_0000_0000_0024)) uut_wide (
    .clk(clk), .rst_n(rst_n), .wr_valid(w_valid), .wr_data(w_data),
    .wr_priv(2'd0), .save_req(64'hFFFF_FFFF_FFFF_FFFF), .enable_q(w_enable),
    .save_set(w_save), .fault(w_fault), .fault_cause(w_cause)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one strobed write, expectation pushed for the monitor
  task automatic drive(input logic [63:0] d, input logic [1:0] p, input string tag);
    logic [1:0] c;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_priv = p;
    if (p != 2'd0)               c = 2'b01;
    else if (!d[0])              c = 2'b10;
    else if ((d & ~CAP_DEF) != 0) c = 2'b11;
    else                         c = 2'b00;
    if (c == 2'b00) model_en = d;
    q.push_back('{en: model_en, flt: (c != 2'b00), cause: c, tag: tag});
  endtask

  // driver: a cycle without strobe, with junk on the data lines
  task automatic idle(input string tag);
    @(negedge clk);
    wr_valid = 1'b0; wr_data = 64'hFFFF_FFFF_FFFF_FFFE; wr_priv = 2'd3;
    q.push_back('{en: model_en, flt: 1'b0, cause: 2'b00, tag: tag});
  endtask

  // monitor: compares just after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " enable"}, enable_q, e.en);
        check({e.tag, " fault"}, {63'd0, fault}, {63'd0, e.flt});
        check({e.tag, " cause"}, {62'd0, fault_cause}, {62'd0, e.cause});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_priv = '0;
    save_req = '0; w_valid = 1'b0; w_data = '0;
    model_en = 64'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 reset enable", enable_q, 64'h1);
    check("R1 reset fault", {63'd0, fault}, 64'd0);
    check("R1 reset cause", {62'd0, fault_cause}, 64'd0);

    drive(64'h3, 2'd0, "R2 enable both");      idle("R6 no fault after accept");
    drive(64'h1, 2'd0, "R2 base only");        idle("R6 idle data ignored");
    drive(64'h3, 2'd0, "R2 re-enable");        idle("R6 pulse ends");
    drive(64'h2, 2'd0, "R3 base clear");       idle("R6 pulse ends R3");
    drive(64'h0, 2'd0, "R3 write zero");       idle("R6 pulse ends R3b");
    drive(64'h5, 2'd0, "R4 bit2");             idle("R6 pulse ends R4");
    drive(64'h8000_0000_0000_0003, 2'd0, "R4 bit63");
    drive(64'h1, 2'd1, "R5 priv1");
    drive(64'h1, 2'd3, "R5 priv3");
    drive(64'h8000_0000_0000_0000, 2'd2, "R7 all causes priv wins");
    drive(64'h4, 2'd0, "R7 base beats unsup");
    drive(64'h2, 2'd0, "R6 back to back a");
    drive(64'h2, 2'd0, "R6 back to back b");
    drive(64'h1, 2'd0, "R2 accept after reject");
    drive(64'h3, 2'd0, "R2 restore");
    idle("R6 final idle");
    repeat (3) @(negedge clk);

    // save set: combinational, current register value 3
    save_req = 64'hFFFF_FFFF_FFFF_FFFF; #0.5;
    check("R8 full mask", save_set, 64'h3);
    save_req = 64'h2; #0.5;
    check("R8 vector only", save_set, 64'h2);
    save_req = 64'hFFFF_FFFF_FFFF_FFFC; #0.5;
    check("R8 no overlap", save_set, 64'h0);
    drive(64'h1, 2'd0, "R2 base only again");
    idle("R6 idle again");
    repeat (3) @(negedge clk);
    save_req = 64'hFFFF_FFFF_FFFF_FFFF; #0.5;
    check("R8 disabled group dropped", save_set, 64'h1);

    // wide instance: bit 0 forced supported, bit 63 forced unsupported
    @(negedge clk); w_valid = 1'b1; w_data = 64'h25;
    @(negedge clk); w_valid = 1'b0;
    check("R9 bit0 forced writable", w_enable, 64'h25);
    check("R9 accept no fault", {63'd0, w_fault}, 64'd0);
    @(negedge clk); w_valid = 1'b1; w_data = 64'h8000_0000_0000_0025;
    @(negedge clk); w_valid = 1'b0;
    check("R9 bit63 rejected", w_enable, 64'h25);
    check("R9 bit63 fault", {63'd0, w_fault}, 64'd1);
    check("R9 bit63 cause", {62'd0, w_cause}, 64'd3);
    @(negedge clk);
    check("R6 wide pulse one cycle", {63'd0, w_fault}, 64'd0);
    check("R9 save set", w_save, 64'h25);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule